// File: doc/BRIEF.md
# Alarm Timer with Reload and Snapshot

This block is a single free-running time base of 54 bits driven by a programmable prescaler. Software configures it through a simple synchronous register bus: it can stop or start counting, choose the count direction, set a divider for the count tick, and load the counter at any moment from a pair of load registers. Because the live counter is wider than the bus, a read goes through a snapshot. Software writes the snapshot request register, and the counter value is then held in two readable words until the next request, so the two halves always belong together.

A 54-bit alarm value is compared with the counter while the alarm is armed. On a match the block disarms itself and sets a raw interrupt flag. If automatic reload is selected, it also puts the load value back into the counter in the same cycle. The raw flag is ANDed with an enable bit to drive the interrupt output. Software clears the flag by writing 1 to a clear register.

The register bus is a control path, not a data stream. There is no valid/ready handshake and no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `tmr_alarm_timer`

## Requirements
- R1: After reset the control word reads 0x0001_0006, which means stopped, counting up, automatic reload on, disarmed and divider 1. The counter, the snapshot, the alarm and load values, the interrupt enable and the raw flag are all 0, so `irq` is low.
- R2: The register map uses word addresses on `bus_addr`:
  - 0x0 control: bit 0 run, bit 1 up, bit 2 auto-reload, bit 3 arm, bits 31:16 divider.
  - 0x1 snapshot low 32 bits; 0x2 snapshot high 22 bits. Both are read-only.
  - 0x3 snapshot request, write any value.
  - 0x4 and 0x5 alarm low and high.
  - 0x6 and 0x7 load low and high.
  - 0x8 load request, write any value.
  - 0x9 interrupt enable, bit 0.
  - 0xA raw flag, bit 0.
  - 0xB masked flag, bit 0.
  - 0xC clear: writing 1 to bit 0 clears the raw flag.
  - Write-only addresses read as 0.
- R3: While running, the counter steps once every D clock cycles, where D is the divider. A divider of 0 behaves as 1. The first step comes D cycles after the write that sets run.
- R4: With up=1 each step adds 1. With up=0 each step subtracts 1. The counter wraps modulo 2^54 in both directions.
- R5: With run=0 the counter does not change, except through a load request or an alarm reload.
- R6: A write to the snapshot request copies the counter value as it stood just before that edge. The snapshot words then hold that value, even while counting goes on, until the next request.
- R7: A write to the load request puts the 54-bit load value into the counter at that edge. Counting resumes from that value on the next edge.
- R8: While armed, a counter value equal to the 54-bit alarm value fires the alarm on the next edge. The raw flag sets and the arm bit clears. While disarmed, no match ever sets the flag.
- R9: When the alarm fires with auto-reload set, the counter takes the load value at that edge. With auto-reload clear, the counter keeps counting through the match.
- R10: `irq` and the masked flag equal the raw flag AND the enable bit. Writing 1 to the clear register drops the raw flag.
- R11: If a clear write and an alarm fire fall on the same edge, the raw flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe, acts at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Alarm interrupt: raw flag AND enable |

## Verification
All counter state is visible at the ports only through the snapshot. A wrong step, a wrong direction, a missed wrap or a bad reload therefore shows up as a wrong snapshot value on the first request after the fault. The bench places each request a known number of edges after the control write, so the exact expected count can be computed. A faulty alarm comparison or arm clear shows within one read of the raw flag or the control word after the match cycle. Prescaler phase errors shift the snapshot by at least one step within a few divider periods.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BUS_AW = 4;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned DIV_W  = 16;

  localparam logic [BUS_AW-1:0] A_CTRL     = 4'h0;
  localparam logic [BUS_AW-1:0] A_SNAP_LO  = 4'h1;
  localparam logic [BUS_AW-1:0] A_SNAP_HI  = 4'h2;
  localparam logic [BUS_AW-1:0] A_SNAP_REQ = 4'h3;
  localparam logic [BUS_AW-1:0] A_ALM_LO   = 4'h4;
  localparam logic [BUS_AW-1:0] A_ALM_HI   = 4'h5;
  localparam logic [BUS_AW-1:0] A_LD_LO    = 4'h6;
  localparam logic [BUS_AW-1:0] A_LD_HI    = 4'h7;
  localparam logic [BUS_AW-1:0] A_LD_REQ   = 4'h8;
  localparam logic [BUS_AW-1:0] A_IRQ_EN   = 4'h9;
  localparam logic [BUS_AW-1:0] A_IRQ_RAW  = 4'hA;
  localparam logic [BUS_AW-1:0] A_IRQ_MSK  = 4'hB;
  localparam logic [BUS_AW-1:0] A_IRQ_CLR  = 4'hC;

  localparam int unsigned CTL_RUN     = 0;
  localparam int unsigned CTL_UP      = 1;
  localparam int unsigned CTL_AUTO    = 2;
  localparam int unsigned CTL_ARM     = 3;
  localparam int unsigned CTL_DIV_LSB = 16;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             arm;
    logic             auto_rl;
    logic             up;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] div_eff;

  always_comb begin
    div_eff = (div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div;
    tick    = run && (phase_q >= div_eff - {{(DIV_W-1){1'b0}}, 1'b1});
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) phase_q <= '0;
    else                        phase_q <= phase_q + {{(DIV_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             up,
  input  logic             auto_rl,
  input  logic             arm,
  input  logic [CNT_W-1:0] alarm_val,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_req,
  output logic [CNT_W-1:0] cnt,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assign fire = arm && (cnt == alarm_val);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (load_req)         cnt <= load_val;
    else if (fire && auto_rl)  cnt <= load_val;
    else if (tick)             cnt <= up ? cnt + ONE : cnt - ONE;
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              fire,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  alarm_val,
  output logic [CNT_W-1:0]  load_val,
  output logic              load_req,
  output logic [CNT_W-1:0]  snap,
  output logic              raw,
  output logic              irq_en
);
  localparam int unsigned HI_W = CNT_W - BUS_DW;

  logic wr_ctrl, wr_snap, wr_alo, wr_ahi, wr_llo, wr_lhi, wr_en, wr_clr;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    wr_snap  = bus_wr && (bus_addr == A_SNAP_REQ);
    wr_alo   = bus_wr && (bus_addr == A_ALM_LO);
    wr_ahi   = bus_wr && (bus_addr == A_ALM_HI);
    wr_llo   = bus_wr && (bus_addr == A_LD_LO);
    wr_lhi   = bus_wr && (bus_addr == A_LD_HI);
    load_req = bus_wr && (bus_addr == A_LD_REQ);
    wr_en    = bus_wr && (bus_addr == A_IRQ_EN);
    wr_clr   = bus_wr && (bus_addr == A_IRQ_CLR) && bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl.run     <= 1'b0;
      ctrl.up      <= 1'b1;
      ctrl.auto_rl <= 1'b1;
      ctrl.arm     <= 1'b0;
      ctrl.div     <= {{(DIV_W-1){1'b0}}, 1'b1};
    end else if (wr_ctrl) begin
      ctrl.run     <= bus_wdata[CTL_RUN];
      ctrl.up      <= bus_wdata[CTL_UP];
      ctrl.auto_rl <= bus_wdata[CTL_AUTO];
      ctrl.arm     <= bus_wdata[CTL_ARM];
      ctrl.div     <= bus_wdata[CTL_DIV_LSB +: DIV_W];
    end else if (fire) begin
      ctrl.arm     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_val <= '0;
      load_val  <= '0;
    end else begin
      if (wr_alo) alarm_val[BUS_DW-1:0]     <= bus_wdata;
      if (wr_ahi) alarm_val[CNT_W-1:BUS_DW] <= bus_wdata[HI_W-1:0];
      if (wr_llo) load_val[BUS_DW-1:0]      <= bus_wdata;
      if (wr_lhi) load_val[CNT_W-1:BUS_DW]  <= bus_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap   <= '0;
      raw    <= 1'b0;
      irq_en <= 1'b0;
    end else begin
      if (wr_snap) snap   <= cnt;
      if (wr_en)   irq_en <= bus_wdata[0];
      if (fire)        raw <= 1'b1;
      else if (wr_clr) raw <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[CTL_RUN]              = ctrl.run;
        bus_rdata[CTL_UP]               = ctrl.up;
        bus_rdata[CTL_AUTO]             = ctrl.auto_rl;
        bus_rdata[CTL_ARM]              = ctrl.arm;
        bus_rdata[CTL_DIV_LSB +: DIV_W] = ctrl.div;
      end
      A_SNAP_LO: bus_rdata             = snap[BUS_DW-1:0];
      A_SNAP_HI: bus_rdata[HI_W-1:0]   = snap[CNT_W-1:BUS_DW];
      A_ALM_LO:  bus_rdata             = alarm_val[BUS_DW-1:0];
      A_ALM_HI:  bus_rdata[HI_W-1:0]   = alarm_val[CNT_W-1:BUS_DW];
      A_LD_LO:   bus_rdata             = load_val[BUS_DW-1:0];
      A_LD_HI:   bus_rdata[HI_W-1:0]   = load_val[CNT_W-1:BUS_DW];
      A_IRQ_EN:  bus_rdata[0]          = irq_en;
      A_IRQ_RAW: bus_rdata[0]          = raw;
      A_IRQ_MSK: bus_rdata[0]          = raw & irq_en;
      default:   bus_rdata             = '0;
    endcase
  end
endmodule

// File: rtl/tmr_alarm_timer.sv
module tmr_alarm_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] alarm_val, load_val, cnt, snap;
  logic             load_req, fire, tick, raw, irq_en;

  tmr_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt), .fire(fire),
    .ctrl(ctrl), .alarm_val(alarm_val), .load_val(load_val),
    .load_req(load_req), .snap(snap), .raw(raw), .irq_en(irq_en)
  );

  tmr_prescale pre_i (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .div(ctrl.div), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .up(ctrl.up),
    .auto_rl(ctrl.auto_rl), .arm(ctrl.arm), .alarm_val(alarm_val),
    .load_val(load_val), .load_req(load_req), .cnt(cnt), .fire(fire)
  );

  assign irq = raw & irq_en;
endmodule

// File: rtl/tmr_alarm_timer_chk.sv
module tmr_alarm_timer_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 54
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic              tick,
  input logic              fire,
  input logic              arm,
  input logic              auto_rl,
  input logic              run,
  input logic [DIV_W-1:0]  div,
  input logic              raw,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  load_val,
  input logic              load_req,
  input logic [CNT_W-1:0]  snap,
  input logic              irq
);
  logic ctl_wr, snap_wr, clr_wr;
  assign ctl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign snap_wr = bus_wr && (bus_addr == A_SNAP_REQ);
  assign clr_wr  = bus_wr && (bus_addr == A_IRQ_CLR) && bus_wdata[0];

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && div > 1 && !ctl_wr) |=> !tick);
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !fire && !load_req) |=> $stable(cnt));
  p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_wr |=> $stable(snap));
  p_load_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> cnt == $past(load_val));
  p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctl_wr) |=> !arm);
  p_raw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> raw);
  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && auto_rl && !load_req) |=> cnt == $past(load_val));
  p_irq_raw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> raw);
  p_alarm_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && clr_wr) |=> raw);
endmodule

bind tmr_alarm_timer tmr_alarm_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .tick(tick), .fire(fire), .arm(ctrl.arm),
  .auto_rl(ctrl.auto_rl), .run(ctrl.run), .div(ctrl.div), .raw(raw),
  .cnt(cnt), .load_val(load_val), .load_req(load_req), .snap(snap), .irq(irq)
);

// File: tb/tmr_alarm_timer_tb_top.sv
`timescale 1ns/1ps
module tmr_alarm_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  tmr_alarm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [53:0] ALL1 = {54{1'b1}};

  function automatic logic [31:0] ctl(input bit run, input bit up, input bit au,
                                      input bit arm, input logic [15:0] dv);
    return {dv, 12'h0, arm, au, up, run};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_snap(output logic [53:0] v);
    logic [31:0] lo, hi;
    rd(4'h1, lo);
    rd(4'h2, hi);
    v = {hi[21:0], lo};
  endtask

  task automatic setup(input logic [53:0] l);
    logic [31:0] d;
    wr(4'h0, 32'h0);
    wr(4'hC, 32'h1);
    wr(4'h6, l[31:0]);
    wr(4'h7, {10'h0, l[53:32]});
    wr(4'h8, 32'h0);
    rd(4'hA, d);
  endtask

  task automatic set_alarm(input logic [53:0] a);
    wr(4'h4, a[31:0]);
    wr(4'h5, {10'h0, a[53:32]});
  endtask

  // control write at edge E0, snapshot request at edge E(m+2)
  task automatic run_snap(input logic [31:0] c, input int m, output logic [53:0] v);
    wr(4'h0, c);
    repeat (m) @(negedge clk);
    wr(4'h3, 32'h0);
    rd_snap(v);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [53:0] v;
    rd(4'h0, d);  chk("R1", "ctrl reset", d, 32'h0001_0006);
    rd(4'hA, d);  chk("R1", "raw reset", d, 0);
    chk("R1", "irq reset", irq, 0);
    rd(4'h3, d);  chk("R2", "write-only reads 0", d, 0);
    wr(4'h3, 32'h0);
    rd_snap(v);   chk("R1", "counter reset", v, 0);
  endtask

  task automatic t_prescale;
    logic [53:0] v;
    setup(0);
    run_snap(ctl(1,1,0,0,16'd4), 20, v);
    chk("R3", "divide by 4", v, 21/4);
    setup(0);
    run_snap(ctl(1,1,0,0,16'd0), 4, v);
    chk("R3", "divider 0 as 1", v, 5);
    setup(100);
    run_snap(ctl(1,1,0,0,16'd3), 7, v);
    chk("R3", "divide by 3", v, 100 + 8/3);
  endtask

  task automatic t_direction;
    logic [53:0] v;
    setup(10);
    run_snap(ctl(1,0,0,0,16'd2), 9, v);
    chk("R4", "count down div 2", v, 5);
    setup(0);
    run_snap(ctl(1,0,0,0,16'd1), 0, v);
    chk("R4", "wrap below zero", v, {10'h0, ALL1});
    setup(ALL1);
    run_snap(ctl(1,1,0,0,16'd1), 0, v);
    chk("R4", "wrap above max", v, 0);
  endtask

  task automatic t_stopped;
    logic [53:0] v;
    setup(54'd123);
    run_snap(ctl(0,1,0,0,16'd1), 10, v);
    chk("R5", "stopped counter holds", v, 123);
  endtask

  task automatic t_snapshot;
    logic [53:0] v;
    setup(0);
    run_snap(ctl(1,1,0,0,16'd1), 3, v);
    chk("R6", "snapshot value", v, 4);
    repeat (10) @(negedge clk);
    rd_snap(v);
    chk("R6", "snapshot holds while running", v, 4);
  endtask

  task automatic t_load;
    logic [53:0] v;
    setup(0);
    wr(4'h0, ctl(1,1,0,0,16'd1));
    wr(4'h6, 32'd1000);
    wr(4'h7, 32'd0);
    wr(4'h8, 32'h0);
    wr(4'h3, 32'h0);
    rd_snap(v);
    chk("R7", "load while running", v, 1001);
  endtask

  task automatic t_alarm_reload;
    logic [53:0] v; logic [31:0] d;
    setup(0);
    set_alarm(5);
    run_snap(ctl(1,1,1,1,16'd1), 20, v);
    chk("R9", "auto reload count", v, 15);
    rd(4'hA, d); chk("R8", "raw set", d, 1);
    rd(4'h0, d); chk("R8", "arm self clear", d[3], 0);
    chk("R10", "irq masked", irq, 0);
    rd(4'hB, d); chk("R10", "masked flag off", d, 0);
    wr(4'h9, 32'h1);
    rd(4'hB, d); chk("R10", "masked flag on", d, 1);
    chk("R10", "irq on", irq, 1);
    wr(4'hC, 32'h1);
    rd(4'hA, d); chk("R10", "raw cleared", d, 0);
    chk("R10", "irq off after clear", irq, 0);
  endtask

  task automatic t_alarm_noreload;
    logic [53:0] v; logic [31:0] d;
    setup(0);
    set_alarm(5);
    run_snap(ctl(1,1,0,1,16'd1), 20, v);
    chk("R9", "no reload keeps counting", v, 21);
    rd(4'hA, d); chk("R8", "raw set no reload", d, 1);
    setup(0);
    set_alarm(5);
    run_snap(ctl(1,1,1,0,16'd1), 20, v);
    chk("R8", "disarmed no reload", v, 21);
    rd(4'hA, d); chk("R8", "disarmed raw stays 0", d, 0);
  endtask

  task automatic t_alarm_high;
    logic [53:0] v; logic [31:0] d;
    setup({22'd5, 32'hFFFF_FFFE});
    set_alarm({22'd6, 32'h0000_0001});
    run_snap(ctl(1,1,1,1,16'd1), 10, v);
    chk("R9", "54-bit match and reload", v, {22'd6, 32'h0000_0005});
    rd(4'hA, d); chk("R8", "raw set high match", d, 1);
  endtask

  task automatic t_race;
    logic [31:0] d;
    setup(54'd7);
    set_alarm(54'd7);
    @(negedge clk);
    bus_addr = 4'h0; bus_wdata = ctl(0,1,0,1,16'd1); bus_wr = 1'b1;
    @(negedge clk);
    bus_addr = 4'hC; bus_wdata = 32'h1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(4'hA, d); chk("R11", "alarm beats clear", d, 1);
    wr(4'hC, 32'h1);
    rd(4'hA, d); chk("R11", "plain clear after race", d, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_prescale;
    t_direction;
    t_stopped;
    t_snapshot;
    t_load;
    t_alarm_reload;
    t_alarm_noreload;
    t_alarm_high;
    t_race;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule